// File: doc/BRIEF.md
# Process ID address relocation unit

This block sits between the core's virtual address output and the caches and MMU. Each running process is given a number. When a virtual address falls in the lowest 32 MB window, the block moves it into a 32 MB slot chosen by that process number, so processes that were all linked at address zero do not overlap. Addresses above the window pass through unchanged. Relocation is also skipped when the MMU is off, and when the address belongs to a by-address cache or TLB maintenance operation.

The process number sits in a 7-bit register with its own write port, which gives 128 slots. The relocated address is registered, so it appears one cycle after its input, and a valid bit travels alongside it. A write to the process number affects addresses presented from the next cycle onward.

Top module: `pid_reloc`

## Requirements
- R1: After reset the output valid bit `mva_valid_o` is 0 and the process number is 0.
- R2: For an address with bits [31:25] all zero, when the MMU is on and the maintenance flag is clear, the output equals the input with bits [31:25] replaced by the process number. This is the same as A + PID × 32 MB.
- R3: An address with any of bits [31:25] set is output unchanged.
- R4: With a process number of 0, every address is output unchanged.
- R5: When `mmu_en_i` is 0, every address is output unchanged.
- R6: When `maint_i` is 1, every address is output unchanged.
- R7: The output address and its valid bit appear exactly one clock cycle after the input. `mva_valid_o` follows `va_valid_i` one cycle late.
- R8: A process number written in cycle N (`pid_we_i` = 1) applies to addresses presented in cycle N+1 and later. An address presented in cycle N itself uses the old number.
- R9: The process number field is 7 bits wide, so values 0 to 127 select 128 slots, and slot 127 maps to the top 32 MB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| va_i | input | 32 | Virtual address from the core |
| va_valid_i | input | 1 | Address valid |
| mmu_en_i | input | 1 | MMU enabled; relocation only when 1 |
| maint_i | input | 1 | Address belongs to a by-address maintenance operation |
| pid_we_i | input | 1 | Process number write enable |
| pid_wdata_i | input | 7 | Process number write data |
| mva_o | output | 32 | Relocated address, registered |
| mva_valid_o | output | 1 | Relocated address valid |

## Verification
A write to the process number can land in the same cycle as an address lookup. The bench provokes this by driving `pid_we_i` and a low-window address together, then presenting a second low address in the very next cycle. It judges the result by checking that the first address was relocated with the old number and the second with the new one. Bypass conditions are also combined with a non-zero process number in the same cycle, to show that a bypass always overrides relocation.

// File: rtl/pid_reloc_pkg.sv
package pid_reloc_pkg;
  parameter int unsigned ADDR_W = 32;
  parameter int unsigned PID_W  = 7;
  localparam int unsigned LOW_W = ADDR_W - PID_W;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [PID_W-1:0]  pid_t;
endpackage

// File: rtl/pid_reg.sv
module pid_reg
  import pid_reloc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  pid_t wdata_i,
  output pid_t pid_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   pid_o <= '0;
    else if (we_i) pid_o <= wdata_i;

  // R1
  pid_reset_chk: assert property (@(posedge clk_i) $rose(rst_ni) |-> pid_o == '0);
  // R8
  pid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(pid_o));
endmodule

// File: rtl/reloc_comb.sv
module reloc_comb
  import pid_reloc_pkg::*;
(
  input  addr_t va_i,
  input  pid_t  pid_i,
  input  logic  mmu_en_i,
  input  logic  maint_i,
  output addr_t mva_o
);
  logic in_low;
  // Substitution replaces the add: the top field is zero whenever the address is in the low window.
  assign in_low = (va_i[ADDR_W-1:LOW_W] == '0) && mmu_en_i && !maint_i;
  assign mva_o  = in_low ? {pid_i, va_i[LOW_W-1:0]} : va_i;

  // R3
  high_pass_chk: assert final (va_i[ADDR_W-1:LOW_W] == '0 || mva_o == va_i);
  // R5
  mmu_off_chk: assert final (mmu_en_i || mva_o == va_i);
  // R6
  maint_pass_chk: assert final (!maint_i || mva_o == va_i);
endmodule

// File: rtl/pid_reloc.sv
module pid_reloc
  import pid_reloc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       va_i,
  input  logic              va_valid_i,
  input  logic              mmu_en_i,
  input  logic              maint_i,
  input  logic              pid_we_i,
  input  logic [6:0]        pid_wdata_i,
  output logic [31:0]       mva_o,
  output logic              mva_valid_o
);
  pid_t  pid_q;
  addr_t mva_d;

  pid_reg u_pid (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(pid_we_i),
    .wdata_i(pid_wdata_i), .pid_o(pid_q)
  );

  reloc_comb u_comb (
    .va_i(va_i), .pid_i(pid_q), .mmu_en_i(mmu_en_i),
    .maint_i(maint_i), .mva_o(mva_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      mva_o       <= '0;
      mva_valid_o <= 1'b0;
    end else begin
      mva_valid_o <= va_valid_i;
      if (va_valid_i) mva_o <= mva_d;
    end

  // R7
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mva_valid_o == $past(va_valid_i));
  // R7
  low_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(va_valid_i) |-> mva_o[LOW_W-1:0] == $past(va_i[LOW_W-1:0]));
  // R4
  pid_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(va_valid_i) && $past(pid_q) == '0) |-> mva_o == $past(va_i));
endmodule

// File: tb/tb_pid_reloc.sv
module tb_pid_reloc;
  logic clk = 0, rst_n = 0;
  logic [31:0] va = 0;
  logic va_v = 0, mmu = 0, mnt = 0, we = 0;
  logic [6:0] wd = 0;
  logic [31:0] mva;
  logic mva_v;
  int runs = 0, fails = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic [6:0] model_pid = 0;

  always #4 clk = ~clk;

  pid_reloc dut (.clk_i(clk), .rst_ni(rst_n), .va_i(va), .va_valid_i(va_v),
    .mmu_en_i(mmu), .maint_i(mnt), .pid_we_i(we), .pid_wdata_i(wd),
    .mva_o(mva), .mva_valid_o(mva_v));

  function automatic logic [31:0] model(logic [31:0] a, logic [6:0] p, logic m, logic x);
    return (a[31:25] == 0 && m && !x) ? {p, a[24:0]} : a;
  endfunction

  task automatic drive(input logic [31:0] a, input logic m, input logic x,
                       input logic w, input logic [6:0] d, input string tag);
    @(negedge clk);
    va = a; va_v = 1; mmu = m; mnt = x; we = w; wd = d;
    exp_q.push_back(model(a, model_pid, m, x));
    tag_q.push_back(tag);
    if (w) model_pid = d;
    @(negedge clk);
    va_v = 0; we = 0;
  endtask

  task automatic drive_b2b(input logic [6:0] d);
    @(negedge clk);
    va = 32'h0000_1230; va_v = 1; mmu = 1; mnt = 0; we = 1; wd = d;
    exp_q.push_back(model(va, model_pid, 1, 0)); tag_q.push_back("R8 old");
    model_pid = d;
    @(negedge clk);
    we = 0; va = 32'h0000_4560;
    exp_q.push_back(model(va, model_pid, 1, 0)); tag_q.push_back("R8 new");
    @(negedge clk);
    va_v = 0;
  endtask

  // monitor: sample at negedge, valid is one cycle after drive
  always @(negedge clk) if (rst_n && mva_v) begin
    logic [31:0] e; string t;
    runs++;
    if (exp_q.size() == 0) begin
      fails++; $display("FAIL R7 unexpected valid act=%h exp=none", mva);
    end else begin
      e = exp_q.pop_front(); t = tag_q.pop_front();
      if (mva !== e) begin fails++; $display("FAIL %s act=%h exp=%h", t, mva, e); end
    end
  end

  initial begin
    #2000000; fails++; runs++;
    $display("FAIL watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", runs, fails); $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    runs++;
    if (mva_v !== 0) begin fails++; $display("FAIL R1 act=%b exp=0", mva_v); end
    rst_n = 1;
    drive(32'h0123_4567, 1, 0, 0, 0, "R1 R4 pid0");
    drive(32'h01FF_FFFF, 1, 0, 1, 7'd5, "R4 pid0 write");
    drive(32'h0000_0040, 1, 0, 0, 0, "R2 pid5");
    drive(32'h01AB_CDEF, 1, 0, 0, 0, "R2 top of window");
    drive(32'h0200_0000, 1, 0, 0, 0, "R3 32MB boundary");
    drive(32'hFFFF_FFFC, 1, 0, 0, 0, "R3 high");
    drive(32'h0000_1000, 0, 0, 0, 0, "R5 mmu off");
    drive(32'h0000_2000, 1, 1, 0, 0, "R6 maint");
    drive(32'h0100_0000, 1, 0, 1, 7'd127, "R9 write 127");
    drive(32'h01FF_FFF0, 1, 0, 0, 0, "R9 slot 127");
    drive_b2b(7'd3);
    // R7: idle valid low
    @(negedge clk); @(negedge clk);
    runs++;
    if (mva_v !== 0) begin fails++; $display("FAIL R7 act=%b exp=0", mva_v); end
    repeat (2) @(negedge clk);
    runs++;
    if (exp_q.size() != 0) begin fails++; $display("FAIL R7 act=%0d exp=0 pending", exp_q.size()); end
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule